// File: doc/BRIEF.md
# Parallel Scan-Start Input Imager with Edge Flags

This block latches the raw digital inputs of a controller into its input process image once per control-loop scan. In the same clock that captures the image, it evaluates every input for a rising or falling transition and stores one edge flag per input. The processor then reads either the imaged level or the edge flag of any input, without running a software trigger routine for each bit.

The previous-scan level of each input is not kept in dedicated memory cells. It is taken from the image register itself, read just before that register is overwritten. Each input has its own enable bit and direction bit. One global mode bit selects how the first scan after entering run is treated. In safe mode, no edge is reported on that scan. In standard mode, the previous level is assumed to be the idle level of the chosen direction. Edge flags are cleared while the controller is stopped, and the image is frozen while the controller is stopped.

Top module: `edge_image_scan`

## Requirements
- R1: After reset, `image_q` and `edge_q` are all zeros.
- R2: On a clock edge with `run`=1 and `scan_go`=1, `image_q` takes the value of `raw_in` at that edge, and it is visible from the next cycle.
- R3: An enabled input with `det_dir` bit 0 (rising) gets edge flag 1 exactly when its previous image bit is 0 and its newly captured bit is 1.
- R4: An enabled input with `det_dir` bit 1 (falling) gets edge flag 1 exactly when its previous image bit is 1 and its newly captured bit is 0.
- R5: An input whose `det_en` bit is 0 gets edge flag 0 on every capture.
- R6: In a cycle with `run`=1 and `scan_go`=0, both `image_q` and `edge_q` keep their values.
- R7: In any cycle with `run`=0, `edge_q` is cleared at the next edge, and `image_q` is not updated, even if `scan_go` is 1.
- R8: With `std_mode`=0 (safe), the first capture after reset or after any cycle with `run`=0 loads the image and sets all edge flags to 0.
- R9: With `std_mode`=1 (standard), on that first capture the previous level is taken as 0 for rising inputs and 1 for falling inputs.
- R10: All inputs are imaged and edge-evaluated in the same single clock of a capture, with no multi-cycle sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| raw_in | input | N_IN | Raw input levels |
| scan_go | input | 1 | Scan-start strobe; when it is 1 for one clock, a capture happens |
| det_dir | input | N_IN | Per-input direction: 0 for rising, 1 for falling |
| det_en | input | N_IN | Per-input edge detection enable |
| std_mode | input | 1 | 0 for safe first-scan behaviour, 1 for standard first-scan behaviour |
| run | input | 1 | 1 while the controller is running, 0 while it is stopped |
| image_q | output | N_IN | Imaged input levels of the current scan |
| edge_q | output | N_IN | Edge flags of the current scan |

## Verification
Two functions can fall in the same clock: the scan-start strobe and the run/stop indication. The bench provokes this in two ways. First, it asserts the strobe while `run` is low. Second, it raises `run` and the strobe in the same clock. In the first case the image must stay frozen and the edge flags must be cleared. In the second case the capture must be handled as the first scan under the selected mode. Expected images and flags come from a bench model of the scan state, and they are compared one cycle after each edge.

// File: rtl/edge_scan_pkg.sv
package edge_scan_pkg;
  typedef enum logic {
    DET_RISE = 1'b0,
    DET_FALL = 1'b1
  } det_dir_e;

  typedef enum logic {
    FIRST_SAFE = 1'b0,
    FIRST_STD  = 1'b1
  } first_mode_e;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[LAST];
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic scan_go,
  output logic cap_en,
  output logic first_q
);
  logic first_d;

  assign cap_en = run & scan_go;

  // The first-scan marker is armed by reset and by every stopped cycle.
  // The first capture in run consumes it.
  always_comb begin
    first_d = first_q;
    if (!run)        first_d = 1'b1;
    else if (scan_go) first_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= 1'b1;
    else        first_q <= first_d;
  end

  p_first_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> first_q);
  p_first_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> !first_q);
endmodule

// File: rtl/edge_cell.sv
module edge_cell
  import edge_scan_pkg::*;
(
  input  logic prev_lvl,
  input  logic cur_lvl,
  input  logic dir,
  input  logic en,
  input  logic first,
  input  logic std_mode,
  output logic flag
);
  det_dir_e    dir_e;
  first_mode_e mode_e;
  logic        prev_eff;

  assign dir_e  = det_dir_e'(dir);
  assign mode_e = first_mode_e'(std_mode);

  always_comb begin
    prev_eff = prev_lvl;
    if (first) begin
      // Standard mode assumes the idle level of the chosen direction.
      // Safe mode uses the current level, so that no edge can appear.
      if (mode_e == FIRST_STD) prev_eff = (dir_e == DET_FALL);
      else                     prev_eff = cur_lvl;
    end
    if (!en)                    flag = 1'b0;
    else if (dir_e == DET_FALL) flag = prev_eff & ~cur_lvl;
    else                        flag = ~prev_eff & cur_lvl;
  end
endmodule

// File: rtl/edge_image_scan.sv
module edge_image_scan #(
  parameter int N_IN = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] raw_in,
  input  logic            scan_go,
  input  logic [N_IN-1:0] det_dir,
  input  logic [N_IN-1:0] det_en,
  input  logic            std_mode,
  input  logic            run,
  output logic [N_IN-1:0] image_q,
  output logic [N_IN-1:0] edge_q
);
  logic            rst_s_n;
  logic            cap_en;
  logic            first_q;
  logic [N_IN-1:0] flag_w;
  logic [N_IN-1:0] image_d;
  logic [N_IN-1:0] edge_d;

  scan_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  scan_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .run(run), .scan_go(scan_go),
    .cap_en(cap_en), .first_q(first_q));

  // The image register supplies the previous-scan level, so no separate
  // memory cell is needed for each input.
  for (genvar i = 0; i < N_IN; i++) begin : g_cell
    edge_cell u_cell (
      .prev_lvl(image_q[i]), .cur_lvl(raw_in[i]), .dir(det_dir[i]),
      .en(det_en[i]), .first(first_q), .std_mode(std_mode),
      .flag(flag_w[i]));
  end

  always_comb begin
    image_d = image_q;
    edge_d  = edge_q;
    if (!run) begin
      edge_d = '0;
    end else if (cap_en) begin
      image_d = raw_in;
      edge_d  = flag_w;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      image_q <= '0;
      edge_q  <= '0;
    end else begin
      image_q <= image_d;
      edge_q  <= edge_d;
    end
  end

  p_image_capture_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && scan_go) |=> image_q == $past(raw_in));
  p_disabled_zero_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && scan_go) |=> (edge_q & ~$past(det_en)) == '0);
  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && !scan_go) |=> ($stable(image_q) && $stable(edge_q)));
  p_stop_clear_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !run |=> (edge_q == '0 && $stable(image_q)));
  p_safe_first_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && scan_go && first_q && !std_mode) |=> edge_q == '0);
endmodule

// File: tb/edge_image_scan_bench.sv
module edge_image_scan_bench;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] raw_in = '0;
  logic         scan_go = 1'b0;
  logic [N-1:0] det_dir = '0;
  logic [N-1:0] det_en = '0;
  logic         std_mode = 1'b0;
  logic         run = 1'b0;
  logic [N-1:0] image_q;
  logic [N-1:0] edge_q;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_img = '0;
  logic         m_first = 1'b1;
  logic         done = 1'b0;

  always #2.5 clk = ~clk;

  edge_image_scan #(.N_IN(N)) u_edge_image_scan (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .scan_go(scan_go),
    .det_dir(det_dir), .det_en(det_en), .std_mode(std_mode), .run(run),
    .image_q(image_q), .edge_q(edge_q));

  task automatic chk(input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_edges(input logic [N-1:0] prev,
      input logic [N-1:0] cur, input logic [N-1:0] dir,
      input logic [N-1:0] en, input logic first, input logic stdm);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic p;
      p = prev[i];
      if (first) p = stdm ? dir[i] : cur[i];
      r[i] = en[i] & (dir[i] ? (p & ~cur[i]) : (~p & cur[i]));
    end
    return r;
  endfunction

  // One capture in run: apply raw, pulse the strobe, then compare at the negedge.
  task automatic scan(input logic [N-1:0] raw, input string req_img,
                      input string req_edge);
    logic [N-1:0] exp_e;
    @(negedge clk);
    raw_in = raw; scan_go = 1'b1;
    exp_e = model_edges(m_img, raw, det_dir, det_en, m_first, std_mode);
    @(negedge clk);
    scan_go = 1'b0;
    m_img = raw; m_first = 1'b0;
    chk(req_img, image_q, raw);
    chk(req_edge, edge_q, exp_e);
  endtask

  task automatic t_reset();
    chk("R1 image", image_q, '0);
    chk("R1 edge", edge_q, '0);
  endtask

  task automatic t_safe_first();
    std_mode = 1'b0; det_en = '1; det_dir = 16'hAAAA;
    @(negedge clk); run = 1'b1;
    scan(16'h5A3C, "R2 image", "R8 safe first edge");
    chk("R8 all zero", edge_q, '0);
  endtask

  task automatic t_rising();
    det_dir = '0; det_en = '1;
    scan(16'h00F0, "R2 image", "R3 rising");
    scan(16'h0FF0, "R2 image", "R3 rising");
    chk("R3 R10 parallel rise", edge_q, 16'h0F00);
  endtask

  task automatic t_falling();
    det_dir = '1; det_en = '1;
    scan(16'h00F5, "R2 image", "R4 falling");
    chk("R4 R10 parallel fall", edge_q, 16'h0F00);
  endtask

  task automatic t_mask();
    det_dir = 16'h5555; det_en = 16'h00FF;
    scan(16'hFF0A, "R2 image", "R5 masked");
    scan(16'h00F5, "R2 image", "R5 masked");
    chk("R5 upper masked", edge_q & 16'hFF00, '0);
  endtask

  task automatic t_hold();
    logic [N-1:0] si, se;
    si = image_q; se = edge_q;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); raw_in = ~raw_in;
    end
    @(negedge clk);
    chk("R6 image hold", image_q, si);
    chk("R6 edge hold", edge_q, se);
  endtask

  task automatic t_stop_strobe();
    logic [N-1:0] si;
    det_en = '1; det_dir = '0;
    scan(16'h0000, "R2 image", "R3 rise");
    scan(16'h00FF, "R2 image", "R3 rise");
    si = image_q;
    @(negedge clk); run = 1'b0; scan_go = 1'b1; raw_in = 16'hFFFF;
    m_first = 1'b1;
    @(negedge clk); scan_go = 1'b0;
    chk("R7 edge cleared", edge_q, '0);
    chk("R7 image frozen", image_q, si);
  endtask

  task automatic t_std_first_same_cycle();
    logic [N-1:0] exp_e;
    std_mode = 1'b1; det_dir = 16'hFF00; det_en = '1;
    @(negedge clk);
    run = 1'b1; scan_go = 1'b1; raw_in = 16'h0F0F;
    exp_e = model_edges(m_img, 16'h0F0F, det_dir, det_en, 1'b1, 1'b1);
    @(negedge clk); scan_go = 1'b0;
    m_img = 16'h0F0F; m_first = 1'b0;
    chk("R9 std first image", image_q, 16'h0F0F);
    chk("R9 std first edges", edge_q, exp_e);
    chk("R9 std first literal", edge_q, 16'hF00F);
    scan(16'h0F0F, "R2 image", "R9 second scan no edge");
    chk("R9 no repeat", edge_q, '0);
  endtask

  task automatic t_safe_after_stop();
    @(negedge clk); run = 1'b0; m_first = 1'b1;
    @(negedge clk); std_mode = 1'b0; run = 1'b1; det_dir = '0; det_en = '1;
    scan(16'hFFFF, "R2 image", "R8 after stop");
    chk("R8 after stop zero", edge_q, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_safe_first();
    t_rising();
    t_falling();
    t_mask();
    t_hold();
    t_stop_strobe();
    t_std_first_same_cycle();
    t_safe_after_stop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule